// File: doc/BRIEF.md
# PCI Command and Status Register Pair

This block holds the command and status halfwords of the configuration header of a bus-mastering network function. A configuration port reads and writes a 32-bit word through a select input. Select 0 addresses the word with the command register in the low half and the status register in the high half. Select 1 addresses a read-only word that carries the programming-interface byte and the revision byte.

The enable bits in the command register drive the function's decoders and its master engine directly. The status register keeps sticky error flags. Single-cycle event inputs from the bus engine and the parity logic set these flags. Software clears a flag by writing 1 to it and can never set one. A few status bits are constants. Two status bits mirror strap inputs, one for fast back-to-back support and one for the capability list.

Top module: `pci_cmdsts_regs`

## Requirements
- R1: Command bits 0 (I/O decode), 1 (memory decode), 2 (bus mastering), 4 (memory-write-and-invalidate) and 6 (parity response) are written from wdata on a select-0 write with byte enable 0 set. They drive io_en, mem_en, bus_master_en, mwi_en and parity_resp_en, and all reset to 0.
- R2: Command bits 3 and 5 and bits 15:7 always read 0, and writes to them have no effect.
- R3: Status bits 10:9 read 01b, bit 5 reads 1, and bits 6 and 3:0 read 0. Status bit n appears at rdata[16+n].
- R4: Status bit 7 reads strap_fbb and status bit 4 reads strap_cap. Writes to either bit have no effect.
- R5: A cycle with an event input high sets its status flag on the next clock edge: ev_serr sets bit 14, ev_mst_abort sets bit 13, ev_tgt_abort_rcvd sets bit 12 and ev_tgt_abort_sig sets bit 11.
- R6: A select-0 write with byte enable 3 set clears each of status bits 15, 14, 13, 12, 11 and 8 whose wdata bit (16+n) is 1. A 0 leaves the flag unchanged, and no write ever sets a flag.
- R7: Status bit 8 is set only when ev_perr_seen, ev_mst_role and the parity response bit are all 1 in the same cycle.
- R8: ev_par_err sets status bit 15 whatever the value of the parity response bit.
- R9: When an event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R10: perr_req is high in the same cycle that ev_par_err and ev_tgt_role are both high, provided parity response is enabled. Otherwise perr_req is low.
- R11: Byte enables act on their own byte: a write without byte enable 0 leaves the command register unchanged, and a write without byte enable 3 clears no flag.
- R12: With select 1, rdata is {16'h0000, PROG_IF, REV_ID}, and writes with select 1 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Write strobe, one write per cycle it is high |
| cfg_dw_sel | input | 1 | Word select: 0 command/status, 1 identification |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected word (combinational) |
| ev_par_err | input | 1 | Data parity error detected |
| ev_tgt_role | input | 1 | Current transfer is as target |
| ev_perr_seen | input | 1 | PERR driven or sensed |
| ev_mst_role | input | 1 | Current transfer is as master |
| ev_serr | input | 1 | SERR asserted |
| ev_mst_abort | input | 1 | Own master transfer ended by master abort |
| ev_tgt_abort_rcvd | input | 1 | Own master transfer ended by target abort |
| ev_tgt_abort_sig | input | 1 | This function signalled target abort |
| strap_fbb | input | 1 | Fast back-to-back capability strap |
| strap_cap | input | 1 | Capability list present strap |
| io_en | output | 1 | I/O space decode enable |
| mem_en | output | 1 | Memory space decode enable |
| bus_master_en | output | 1 | Bus mastering permitted |
| mwi_en | output | 1 | Memory-write-and-invalidate permitted (else plain write) |
| parity_resp_en | output | 1 | Parity error response enabled |
| perr_req | output | 1 | Request to drive PERR as target |

## Verification
The assertions treat every cycle in which an event input is high as a separate event. They also assume the role inputs are sampled only together with the event they qualify. No assumption is made about how long an input stays high. The bench holds each event for exactly one clock and drives writes as one-cycle strobes. It changes all inputs on the falling edge, and it raises events together with clearing writes only in the collision scenario, where R9 defines the result.

// File: rtl/pci_cmdsts_regs.sv
module pci_cmdsts_regs #(
  parameter logic [7:0] REV_ID  = 8'h10,
  parameter logic [7:0] PROG_IF = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_dw_sel,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        ev_par_err,
  input  logic        ev_tgt_role,
  input  logic        ev_perr_seen,
  input  logic        ev_mst_role,
  input  logic        ev_serr,
  input  logic        ev_mst_abort,
  input  logic        ev_tgt_abort_rcvd,
  input  logic        ev_tgt_abort_sig,
  input  logic        strap_fbb,
  input  logic        strap_cap,
  output logic        io_en,
  output logic        mem_en,
  output logic        bus_master_en,
  output logic        mwi_en,
  output logic        parity_resp_en,
  output logic        perr_req
);
  localparam int NSTICKY = 6;

  logic [4:0]         cmd_q;
  logic [NSTICKY-1:0] sts_q;
  logic [NSTICKY-1:0] sts_set;
  logic [NSTICKY-1:0] sts_clr;
  logic [15:0]        cmd_rd;
  logic [15:0]        sts_rd;
  logic               wr0;

  assign wr0 = cfg_wr & ~cfg_dw_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cmd_q <= '0;
    else if (wr0 && cfg_be[0])
      cmd_q <= {cfg_wdata[6], cfg_wdata[4], cfg_wdata[2:0]};

  assign {parity_resp_en, mwi_en, bus_master_en, mem_en, io_en} = cmd_q;

  // sticky order: {dpe(15), sse(14), rma(13), rta(12), sta(11), dpd(8)}
  assign sts_set = {ev_par_err, ev_serr, ev_mst_abort, ev_tgt_abort_rcvd,
                    ev_tgt_abort_sig, ev_perr_seen & ev_mst_role & cmd_q[4]};
  assign sts_clr = (wr0 && cfg_be[3]) ? {cfg_wdata[31:27], cfg_wdata[24]} : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      sts_q <= '0;
    else
      sts_q <= (sts_q & ~sts_clr) | sts_set;

  assign perr_req = ev_par_err & ev_tgt_role & cmd_q[4];

  assign cmd_rd = {9'b0, cmd_q[4], 1'b0, cmd_q[3], 1'b0, cmd_q[2:0]};
  assign sts_rd = {sts_q[5:1], 2'b01, sts_q[0], strap_fbb, 1'b0, 1'b1, strap_cap, 4'b0};

  assign cfg_rdata = cfg_dw_sel ? {16'h0000, PROG_IF, REV_ID} : {sts_rd, cmd_rd};
endmodule

module pci_cmdsts_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_dw_sel,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        ev_par_err,
  input logic        ev_tgt_role,
  input logic        ev_perr_seen,
  input logic        ev_mst_role,
  input logic        ev_serr,
  input logic        ev_mst_abort,
  input logic        ev_tgt_abort_sig,
  input logic        io_en,
  input logic        mem_en,
  input logic        bus_master_en,
  input logic        mwi_en,
  input logic        parity_resp_en,
  input logic        perr_req,
  input logic [5:0]  sts
);
  assert_serr_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_serr |=> sts[4]);
  assert_mabort_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mst_abort |=> sts[3]);
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_dw_sel && cfg_be[3] && cfg_wdata[30] && !ev_serr) |=> !sts[4]);
  assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[4]) |-> $past(ev_serr));
  assert_dpd_needs_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(ev_perr_seen && ev_mst_role && parity_resp_en));
  assert_dpe_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_par_err |=> sts[5]);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tgt_abort_sig && cfg_wr && !cfg_dw_sel && cfg_be[3] && cfg_wdata[27]) |=> sts[1]);
  assert_perr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !parity_resp_en |-> !perr_req);
  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && !cfg_dw_sel && cfg_be[0]) |=>
      $stable({io_en, mem_en, bus_master_en, mwi_en, parity_resp_en}));
  assert_no_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && !cfg_dw_sel && cfg_be[3]) |=> ((sts & $past(sts)) == $past(sts)));
endmodule

bind pci_cmdsts_regs pci_cmdsts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_sel(cfg_dw_sel),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .ev_par_err(ev_par_err),
  .ev_tgt_role(ev_tgt_role), .ev_perr_seen(ev_perr_seen), .ev_mst_role(ev_mst_role),
  .ev_serr(ev_serr), .ev_mst_abort(ev_mst_abort), .ev_tgt_abort_sig(ev_tgt_abort_sig),
  .io_en(io_en), .mem_en(mem_en), .bus_master_en(bus_master_en), .mwi_en(mwi_en),
  .parity_resp_en(parity_resp_en), .perr_req(perr_req), .sts(sts_q)
);

// File: tb/test_pci_cmdsts_regs.sv
`timescale 1ns/1ps
module test_pci_cmdsts_regs;
  localparam logic [7:0] REV = 8'h10;
  localparam logic [7:0] PIF = 8'h00;
  localparam logic [31:0] BASE = 32'h0220_0000;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_dw_sel = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic ev_par_err = 0, ev_tgt_role = 0, ev_perr_seen = 0, ev_mst_role = 0;
  logic ev_serr = 0, ev_mst_abort = 0, ev_tgt_abort_rcvd = 0, ev_tgt_abort_sig = 0;
  logic strap_fbb = 0, strap_cap = 0;
  logic io_en, mem_en, bus_master_en, mwi_en, parity_resp_en, perr_req;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pci_cmdsts_regs #(.REV_ID(REV), .PROG_IF(PIF)) i_pci_cmdsts_regs (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_dw_sel = sel; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_dw_sel = 0; cfg_be = 0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    cfg_dw_sel = sel; #0.5; d = cfg_rdata; cfg_dw_sel = 0;
  endtask

  // mask: 0 par_err 1 tgt_role 2 perr_seen 3 mst_role 4 serr 5 mst_abort 6 tabort_rcvd 7 tabort_sig
  task automatic set_ev(logic [7:0] m);
    {ev_tgt_abort_sig, ev_tgt_abort_rcvd, ev_mst_abort, ev_serr,
     ev_mst_role, ev_perr_seen, ev_tgt_role, ev_par_err} = m;
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk); set_ev(m);
    @(negedge clk); set_ev(8'h00);
  endtask

  task automatic clear_all();
    wr(0, 4'b1000, 32'hFF00_0000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);
    check("R1 R3 reset word", d, BASE);
    check("R1 reset enables", {27'd0, io_en, mem_en, bus_master_en, mwi_en, parity_resp_en}, 0);
  endtask

  task automatic t_command();
    logic [31:0] d;
    wr(0, 4'b0001, 32'hFFFF_FFFF);
    rd(0, d);
    check("R1 R2 command all-ones", d[15:0], 16'h0057);
    check("R6 no status set by write", d[31:16], 16'h0220);
    check("R1 enable outputs", {27'd0, io_en, mem_en, bus_master_en, mwi_en, parity_resp_en}, 32'h1F);
    wr(0, 4'b1110, 32'h0000_0000);
    rd(0, d);
    check("R11 command held without be0", d[15:0], 16'h0057);
    wr(0, 4'b0001, 32'h0000_0010);
    rd(0, d);
    check("R1 mwi only", d[15:0], 16'h0010);
    check("R1 mwi_en", {31'd0, mwi_en}, 1);
    wr(0, 4'b0001, 32'h0000_0028);
    rd(0, d);
    check("R2 bits 3 5 ignored", d[15:0], 16'h0000);
  endtask

  task automatic t_straps();
    logic [31:0] d;
    @(negedge clk); strap_fbb = 1; strap_cap = 1;
    rd(0, d);
    check("R4 straps high", d[31:16], 16'h02B0);
    wr(0, 4'b1100, 32'hFFFF_0000);
    rd(0, d);
    check("R3 R4 R6 status after ones write", d[31:16], 16'h02B0);
    @(negedge clk); strap_fbb = 0;
    rd(0, d);
    check("R4 fbb low", d[31:16], 16'h0230);
    @(negedge clk); strap_cap = 0;
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(8'h10); rd(0, d); check("R5 serr -> bit14", d[31:16], 16'h4220);
    pulse(8'h20); rd(0, d); check("R5 mabort -> bit13", d[31:16], 16'h6220);
    pulse(8'h40); rd(0, d); check("R5 tabort rcvd -> bit12", d[31:16], 16'h7220);
    pulse(8'h80); rd(0, d); check("R5 tabort sig -> bit11", d[31:16], 16'h7A20);
    wr(0, 4'b0111, 32'hFFFF_FFFF);
    rd(0, d); check("R11 no clear without be3", d[31:16], 16'h7A20);
    wr(0, 4'b1000, 32'h4000_0000);
    rd(0, d); check("R6 clear bit14 only", d[31:16], 16'h3A20);
    wr(0, 4'b1000, 32'h0000_0000);
    rd(0, d); check("R6 zero write keeps", d[31:16], 16'h3A20);
    clear_all();
    rd(0, d); check("R6 clear all", d[31:16], 16'h0220);
    wr(0, 4'b0001, 32'h0);
  endtask

  task automatic t_parity();
    logic [31:0] d;
    pulse(8'h0C); rd(0, d); check("R7 no dpd when response off", d[31:16], 16'h0220);
    pulse(8'h01); rd(0, d); check("R8 dpe with response off", d[31:16], 16'h8220);
    clear_all();
    wr(0, 4'b0001, 32'h0000_0040);
    pulse(8'h04); rd(0, d); check("R7 no dpd without master role", d[31:16], 16'h0220);
    pulse(8'h08); rd(0, d); check("R7 no dpd without perr", d[31:16], 16'h0220);
    pulse(8'h0C); rd(0, d); check("R7 dpd all three", d[31:16], 16'h0320);
    wr(0, 4'b1000, 32'h0100_0000);
    rd(0, d); check("R6 dpd cleared", d[31:16], 16'h0220);
  endtask

  task automatic t_perr_req();
    @(negedge clk); set_ev(8'h03); #0.5;
    check("R10 perr_req on", {31'd0, perr_req}, 1);
    set_ev(8'h01); #0.5;
    check("R10 perr_req needs target", {31'd0, perr_req}, 0);
    @(negedge clk); set_ev(8'h00);
    wr(0, 4'b0001, 32'h0);
    @(negedge clk); set_ev(8'h03); #0.5;
    check("R10 perr_req off when response off", {31'd0, perr_req}, 0);
    @(negedge clk); set_ev(8'h00);
    clear_all();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(8'h80);
    @(negedge clk);
    set_ev(8'h80);
    cfg_wr = 1; cfg_dw_sel = 0; cfg_be = 4'b1000; cfg_wdata = 32'h0800_0000;
    @(negedge clk);
    set_ev(8'h00); cfg_wr = 0; cfg_be = 0;
    rd(0, d); check("R9 set wins over clear", d[31:16], 16'h0A20);
    clear_all();
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd(1, d); check("R12 id word", d, {16'h0000, PIF, REV});
    wr(1, 4'b1111, 32'hFFFF_FFFF);
    rd(0, d); check("R12 select-1 write ignored", d, BASE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_command();
    t_straps();
    t_events();
    t_parity();
    t_perr_req();
    t_set_wins();
    t_ident();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule